// File: doc/BRIEF.md
# Frame Clock Ratio Detector

This block measures how many system-clock cycles make up one period of the audio word-select (frame) signal. The word-select arrives already synchronised into the system-clock domain, and the system clock is assumed to be frequency-locked to it. The measured period is matched against six fixed oversampling multiples: 128, 192, 256, 384, 512 and 768. The result is a compact ratio code that downstream divider logic uses to pick its settings.

A ratio is declared only after several back-to-back frames agree on it. Lock drops as soon as a frame disagrees, does not match any multiple, or word-select stops toggling. While lock is absent, the last confirmed code is held, so the dividers keep a stable setting. A low-rate mode input forbids the 128 multiple.

Top module: `ratio_detect`

## Requirements
- R1: After reset, `ratio_code` is 0, and `locked` and `ratio_err` are both 0.
- R2: A period is the number of clock cycles from one rising edge of `ws_sync` to the next. The first rising edge after reset produces no measurement.
- R3: A period within ±2 cycles of a nominal multiple is accepted. The codes are 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768. The boundary counts 254, 190 and 770 are accepted.
- R4: A period that matches no multiple (for example 189 or 771) sets `ratio_err` and clears `locked`. `ratio_err` returns to 0 at the next accepted period.
- R5: `locked` rises only after 4 consecutive accepted periods of the same multiple, and never after 3.
- R6: An accepted period of a different multiple clears `locked` and starts a new agreement run from a count of one.
- R7: `ratio_code` changes only when lock is declared. While unlocked, it holds the last confirmed code.
- R8: While `low_fs_mode` is 1, a period matching the 128 multiple is treated as a mismatch (R4 behaviour).
- R9: The period counter saturates. If no rising edge arrives within 771 cycles of the last one, `locked` drops and `ratio_err` is set without waiting for another edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_sync | input | 1 | Word-select, already synchronised to `clk` |
| low_fs_mode | input | 1 | Low-rate mode; forbids the 128 multiple |
| ratio_code | output | 3 | Last confirmed ratio code (0..5, ascending) |
| locked | output | 1 | Ratio confirmed over consecutive frames |
| ratio_err | output | 1 | Last period matched no permitted multiple, or word-select stalled |

## Verification
The bench uses the default parameters: a tolerance of 2, a 4-frame agreement window and a 10-bit counter. With these values the tolerance edges (254, 190, 770) and the first rejected counts (189, 771) can be reached with short frames. The stall limit of 771 cycles also sits just above the largest accepted period, so a single long idle gap exercises saturation. The agreement window is small enough that the step between 3 and 4 matching frames can be observed directly.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int NUM_RATIOS = 6;
  localparam int CODE_W     = 3;

  function automatic int nominal_ratio(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      default: return 768;
    endcase
  endfunction

  function automatic int largest_ratio();
    int m;
    m = 0;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (nominal_ratio(i) > m) m = nominal_ratio(i);
    return m;
  endfunction
endpackage

// File: rtl/ws_period_meter.sv
module ws_period_meter #(
  parameter int CNT_W    = 10,
  parameter int STALL_AT = 771
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ws_i,
  output logic             pvalid_o,
  output logic [CNT_W-1:0] period_o,
  output logic             stall_o
);
  localparam logic [CNT_W-1:0] STALL_V = CNT_W'(STALL_AT);
  localparam logic [CNT_W-1:0] SAT_V   = '1;
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic             ws_q, seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = ws_i && !ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      seen_q   <= 1'b0;
      cnt_q    <= '0;
      pvalid_o <= 1'b0;
      period_o <= '0;
      stall_o  <= 1'b0;
    end else begin
      ws_q     <= ws_i;
      pvalid_o <= rise && seen_q;
      stall_o  <= seen_q && !rise && (cnt_q == STALL_V);
      if (rise) begin
        seen_q   <= 1'b1;
        period_o <= cnt_q;
        cnt_q    <= ONE_V;
      end else if (cnt_q != SAT_V) begin
        cnt_q <= cnt_q + ONE_V;
      end
    end
  end

  // R9: the saturated counter holds until an edge restarts it
  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT_V && !rise) |=> (cnt_q == SAT_V));
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import ratio_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0]      period_i,
  input  logic                  low_fs_i,
  output logic [NUM_RATIOS-1:0] hit_vec_o,
  output logic                  hit_o,
  output logic [CODE_W-1:0]     idx_o
);
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(nominal_ratio(g) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(nominal_ratio(g) + TOL);
    logic in_win;
    assign in_win = (period_i >= LO) && (period_i <= HI);
    if (g == 0) begin : g_lowest
      assign hit_vec_o[g] = in_win && !low_fs_i;
    end else begin : g_other
      assign hit_vec_o[g] = in_win;
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (hit_vec_o[i]) idx_o = CODE_W'(i);
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
  import ratio_pkg::*;
#(
  parameter int LOCK_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pvalid_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] idx_i,
  input  logic              stall_i,
  output logic [CODE_W-1:0] code_o,
  output logic              locked_o,
  output logic              err_o
);
  localparam int AGW = $clog2(LOCK_FRAMES + 1);
  localparam logic [AGW-1:0] LIM = AGW'(LOCK_FRAMES);

  logic [CODE_W-1:0] cand_q, cand_n, code_n;
  logic [AGW-1:0]    agree_q, agree_n;
  logic              locked_n, err_n;

  always_comb begin
    cand_n   = cand_q;
    agree_n  = agree_q;
    locked_n = locked_o;
    code_n   = code_o;
    err_n    = err_o;
    if (stall_i || (pvalid_i && !hit_i)) begin
      agree_n  = '0;
      locked_n = 1'b0;
      err_n    = 1'b1;
    end else if (pvalid_i) begin
      err_n = 1'b0;
      if (agree_q != '0 && idx_i == cand_q) begin
        if (agree_q != LIM) agree_n = agree_q + AGW'(1);
      end else begin
        cand_n  = idx_i;
        agree_n = AGW'(1);
      end
      locked_n = (agree_n == LIM);
      if (locked_n) code_n = cand_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= '0;
      agree_q  <= '0;
      locked_o <= 1'b0;
      code_o   <= '0;
      err_o    <= 1'b0;
    end else begin
      cand_q   <= cand_n;
      agree_q  <= agree_n;
      locked_o <= locked_n;
      code_o   <= code_n;
      err_o    <= err_n;
    end
  end

  // R5: lock is only declared on an accepted measurement
  a_r5_lock_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(pvalid_i && hit_i));
  // R7: the reported code moves only when lock is declared
  a_r7_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> $rose(locked_o));
  // R4: error and lock never coexist
  a_r4_err_excludes_lock: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !locked_o);
endmodule

// File: rtl/ratio_detect.sv
module ratio_detect
  import ratio_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 2,
  parameter int LOCK_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ws_sync,
  input  logic              low_fs_mode,
  output logic [CODE_W-1:0] ratio_code,
  output logic              locked,
  output logic              ratio_err
);
  localparam int STALL_AT = largest_ratio() + TOL + 1;
  localparam logic [CNT_W-1:0] LOW_LO = CNT_W'(nominal_ratio(0) - TOL);
  localparam logic [CNT_W-1:0] LOW_HI = CNT_W'(nominal_ratio(0) + TOL);

  logic                  pvalid, stall, hit;
  logic [CNT_W-1:0]      period;
  logic [NUM_RATIOS-1:0] hit_vec;
  logic [CODE_W-1:0]     idx;

  ws_period_meter #(.CNT_W(CNT_W), .STALL_AT(STALL_AT)) i_meter (
    .clk(clk), .rst_n(rst_n), .ws_i(ws_sync),
    .pvalid_o(pvalid), .period_o(period), .stall_o(stall)
  );

  ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) i_class (
    .period_i(period), .low_fs_i(low_fs_mode),
    .hit_vec_o(hit_vec), .hit_o(hit), .idx_o(idx)
  );

  lock_tracker #(.LOCK_FRAMES(LOCK_FRAMES)) i_lock (
    .clk(clk), .rst_n(rst_n), .pvalid_i(pvalid), .hit_i(hit), .idx_i(idx),
    .stall_i(stall), .code_o(ratio_code), .locked_o(locked), .err_o(ratio_err)
  );

  // R3: tolerance windows never overlap
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R8: a 128-class period in low-rate mode raises the error flag
  a_r8_low_rate_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (pvalid && low_fs_mode && period >= LOW_LO && period <= LOW_HI) |=> ratio_err);
endmodule

// File: tb/test_ratio_detect.sv
module test_ratio_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 14;
  localparam int ROW_N  [NROWS] = '{256, 256, 254, 190, 194, 189, 128, 768, 384, 512, 770, 771, 128, 256};
  localparam int ROW_K  [NROWS] = '{4,   1,   3,   4,   1,   2,   5,   5,   5,   5,   5,   2,   5,   5};
  localparam int ROW_LF [NROWS] = '{0,   0,   0,   0,   0,   0,   0,   0,   0,   0,   0,   0,   1,   1};
  localparam int ROW_C  [NROWS] = '{0,   2,   2,   2,   1,   1,   0,   5,   3,   4,   5,   5,   5,   2};
  localparam int ROW_L  [NROWS] = '{0,   1,   1,   0,   1,   0,   1,   1,   1,   1,   1,   0,   0,   1};
  localparam int ROW_E  [NROWS] = '{0,   0,   0,   0,   0,   1,   0,   0,   0,   0,   0,   1,   1,   0};

  logic clk = 1'b0, rst_n = 1'b0, ws_sync = 1'b0, low_fs_mode = 1'b0;
  logic [2:0] ratio_code;
  logic locked, ratio_err;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ratio_detect i_ratio_detect (
    .clk(clk), .rst_n(rst_n), .ws_sync(ws_sync), .low_fs_mode(low_fs_mode),
    .ratio_code(ratio_code), .locked(locked), .ratio_err(ratio_err)
  );

  function automatic string row_tag(input int r);
    case (r)
      0:       return "R5 three frames only";
      1:       return "R5 fourth frame locks";
      2:       return "R3 lower edge 254";
      3:       return "R6 new ratio drops lock, R7 code held";
      4:       return "R3 upper edge 194";
      5:       return "R4 count 189 rejected";
      6:       return "R4 error clears, R3 code 0";
      7:       return "R3 code 5";
      8:       return "R3 code 3";
      9:       return "R3 code 4";
      10:      return "R3 upper edge 770";
      11:      return "R4 count 771 rejected";
      12:      return "R8 128 forbidden in low-rate mode";
      default: return "R8 other ratios allowed in low-rate mode";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int c, input int l, input int e);
    check({tag, " code"}, int'(ratio_code), c);
    check({tag, " locked"}, int'(locked), l);
    check({tag, " err"}, int'(ratio_err), e);
  endtask

  task automatic frames(input int n, input int k);
    for (int f = 0; f < k; f++) begin
      ws_sync = 1'b1;
      repeat (n / 2) @(negedge clk);
      ws_sync = 1'b0;
      repeat (n - n / 2) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset state", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < NROWS; r++) begin
      low_fs_mode = ROW_LF[r][0];
      frames(ROW_N[r], ROW_K[r]);
      check_all(row_tag(r), ROW_C[r], ROW_L[r], ROW_E[r]);
    end
    low_fs_mode = 1'b0;

    // R9: word-select stops after a locked 256 run
    repeat (600) @(negedge clk);
    check_all("R9 stall drops lock", 2, 0, 1);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R1 reset after run", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: first edge after reset is not a measurement
    frames(192, 4);
    check_all("R2 first edge ignored", 0, 0, 0);
    frames(192, 1);
    check_all("R2 lock after four periods", 1, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule